// File: doc/BRIEF.md
# Wake-Up Qualifier and Fail-Safe Source Encoder

This block watches two wake sources while a bus transceiver is parked in one of its low-power states. The first source is the serial bus receive line. The second is a dedicated active-low wake pin. Each source passes through a tick-based glitch filter. When a source qualifies, the block sends a one-cycle wake pulse to the mode controller. It also latches which source fired.

The block keeps a third flag that records a supply undervoltage. In Fail-Safe mode, the latched flags are reported on the transmit-data and receive-data pins as a two-bit code. The transmit-data pin is turned around into an output for this purpose.

The mode controller supplies the current operating mode and consumes the wake pulse. All inputs are synchronous to `clk`. `tick_i` is a one-cycle timebase strobe, and the filter lengths are counted in these strobes. Nothing in the block carries a data stream, so every pin is a plain level or pulse with no handshake.

Top module: `wake_signal_unit`

## Requirements
- R1: Bus wake: a falling edge on `bus_rx_i` (1 recessive, 0 dominant) is followed by a dominant level held across `T_BUS` tick strobes after that edge, and then by a rising edge. This produces exactly one `wake_pulse_o` cycle, in the cycle after the rising edge is sampled. With `tick_i` held high, this means at least `T_BUS+1` dominant samples.
- R2: A dominant level that returns recessive before `T_BUS` ticks have elapsed produces no wake. The detector then waits for a fresh falling edge.
- R3: In Silent mode, a bus wake is accepted only while `txd_i` is high. In Sleep mode, `txd_i` does not gate the bus wake.
- R4: Local wake: a falling edge on `wake_pin_i` followed by a low level held across `T_WK` tick strobes produces one `wake_pulse_o` cycle. No release edge is needed.
- R5: After a local wake, `wake_pin_i` must stay high for `T_REL` consecutive tick strobes before a new falling edge can start another local request. A low level during this window restarts the window.
- R6: In Sleep mode with `vs_uv_i` high, neither source is accepted.
- R7: No wake is accepted in Normal mode (`mode_i`=0) or Fail-Safe mode (`mode_i`=3). Wakes are armed only in Silent (1) and Sleep (2).
- R8: In Fail-Safe mode, `txd_oe_o` is 1 and the pair {`txd_o`,`rxd_o`} reports the latched flags. A bus flag gives 00, a local flag gives 01, an undervoltage flag gives 10, and no flag gives 11.
- R9: Code priority when several flags are set: bus over local over undervoltage.
- R10: The undervoltage flag is set in every cycle that `vs_uv_i` is high. It stays set after `vs_uv_i` falls.
- R11: All flags clear in the cycle after `en_i` is high in Normal mode. `en_i` high in any other mode clears nothing.
- R12: Outside Fail-Safe mode, `txd_oe_o` is 0 and `txd_o` is 1. `rxd_o` follows `bus_rx_i` in Normal mode, is 1 in Silent mode and is 0 in Sleep mode.
- R13: After reset, no flag is set and `wake_pulse_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Filter timebase strobe |
| mode_i | input | 2 | Operating mode: 0 Normal, 1 Silent, 2 Sleep, 3 Fail-Safe |
| en_i | input | 1 | Enable level from the host |
| txd_i | input | 1 | Transmit-data level driven by the host |
| vs_uv_i | input | 1 | Supply undervoltage flag |
| bus_rx_i | input | 1 | Bus receive level, 0 = dominant |
| wake_pin_i | input | 1 | Local wake pin, active low |
| wake_pulse_o | output | 1 | One-cycle wake request to the mode controller |
| txd_o | output | 1 | Transmit-data pin level when turned around |
| txd_oe_o | output | 1 | Output enable for the transmit-data pin |
| rxd_o | output | 1 | Receive-data pin level |

## Verification
Suppose a filter counter is off by one. The `wake_pulse_o` count then goes wrong on the exact-threshold hold, one cycle after the release edge, or at the end of the lockout window. A corrupted arming state shows as a pulse in a mode or a TXD level where none may appear. A wrong flag, a missed clear or a wrong priority shows as a wrong two-bit code on the very next Fail-Safe cycle. The mode-dependent RXD level is compared every cycle during a long random run.

// File: rtl/wake_pkg.sv
package wake_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL   = 2'd0,
    MODE_SILENT   = 2'd1,
    MODE_SLEEP    = 2'd2,
    MODE_FAILSAFE = 2'd3
  } op_mode_e;

  typedef struct packed {
    logic bus;
    logic loc;
    logic uv;
  } wake_src_t;

  typedef enum logic [1:0] {
    FLT_IDLE = 2'd0,
    FLT_HOLD = 2'd1,
    FLT_QUAL = 2'd2,
    FLT_LOCK = 2'd3
  } flt_state_e;

endpackage

// File: rtl/bus_wake_filter.sv
module bus_wake_filter
  import wake_pkg::*;
#(
  parameter int FILT_TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic armed_i,
  input  logic line_i,
  output logic req_o
);
  localparam int CW = $clog2(FILT_TICKS + 1);

  flt_state_e    state;
  logic [CW-1:0] cnt;
  logic          line_q;
  logic          req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= FLT_IDLE;
      cnt    <= '0;
      line_q <= 1'b1;
      req_q  <= 1'b0;
    end else begin
      line_q <= line_i;
      req_q  <= 1'b0;
      if (!armed_i) begin
        state <= FLT_IDLE;
        cnt   <= '0;
      end else begin
        case (state)
          FLT_IDLE: begin
            if (line_q && !line_i) begin
              state <= FLT_HOLD;
              cnt   <= '0;
            end
          end
          FLT_HOLD: begin
            if (line_i) begin
              state <= FLT_IDLE;
            end else if (tick_i) begin
              if (cnt == CW'(FILT_TICKS - 1)) state <= FLT_QUAL;
              else cnt <= cnt + 1'b1;
            end
          end
          FLT_QUAL: begin
            if (line_i) begin
              req_q <= 1'b1;
              state <= FLT_IDLE;
            end
          end
          default: state <= FLT_IDLE;
        endcase
      end
    end
  end

  assign req_o = req_q;

  // R1: a request follows a sampled rising edge of the line
  a_r1_req_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> ($past(line_i) && !$past(line_q)));

  // R1: the request lasts one cycle
  a_r1_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);

  // R2: qualification only on a tick while the line stays dominant
  a_r2_qual_needs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == FLT_QUAL && $past(state == FLT_HOLD)) |-> ($past(tick_i) && !$past(line_i)));

endmodule

// File: rtl/local_wake_filter.sv
module local_wake_filter
  import wake_pkg::*;
#(
  parameter int FILT_TICKS  = 6,
  parameter int REARM_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic armed_i,
  input  logic pin_i,
  output logic req_o
);
  localparam int MAXT = (FILT_TICKS > REARM_TICKS) ? FILT_TICKS : REARM_TICKS;
  localparam int CW   = $clog2(MAXT + 1);

  flt_state_e    state;
  logic [CW-1:0] cnt;
  logic          pin_q;
  logic          req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= FLT_IDLE;
      cnt   <= '0;
      pin_q <= 1'b1;
      req_q <= 1'b0;
    end else begin
      pin_q <= pin_i;
      req_q <= 1'b0;
      case (state)
        FLT_IDLE: begin
          if (armed_i && pin_q && !pin_i) begin
            state <= FLT_HOLD;
            cnt   <= '0;
          end
        end
        FLT_HOLD: begin
          if (!armed_i || pin_i) begin
            state <= FLT_IDLE;
            cnt   <= '0;
          end else if (tick_i) begin
            if (cnt == CW'(FILT_TICKS - 1)) begin
              req_q <= 1'b1;
              state <= FLT_LOCK;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        FLT_LOCK: begin
          if (!pin_i) begin
            cnt <= '0;
          end else if (tick_i) begin
            if (cnt == CW'(REARM_TICKS - 1)) begin
              state <= FLT_IDLE;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: state <= FLT_IDLE;
      endcase
    end
  end

  assign req_o = req_q;

  // R4: a request is raised while the pin is still low
  a_r4_req_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> !$past(pin_i));

  // R5: lockout is left only after a high sample on a tick
  a_r5_rearm_on_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state == FLT_IDLE && $past(state == FLT_LOCK)) |-> ($past(pin_i) && $past(tick_i)));

  // R5: no new hold starts straight out of lockout
  a_r5_no_direct_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == FLT_HOLD) |-> !$past(state == FLT_LOCK));

endmodule

// File: rtl/wake_src_latch.sv
module wake_src_latch
  import wake_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bus_req_i,
  input  logic      loc_req_i,
  input  logic      uv_i,
  input  logic      clear_i,
  output wake_src_t flags_o
);
  wake_src_t flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (clear_i) begin
      flags_q <= '0;
    end else begin
      flags_q.bus <= flags_q.bus | bus_req_i;
      flags_q.loc <= flags_q.loc | loc_req_i;
      flags_q.uv  <= flags_q.uv  | uv_i;
    end
  end

  assign flags_o = flags_q;

  // R11: a clear request empties every flag
  a_r11_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (flags_q == '0));

  // R10: the undervoltage flag holds until cleared
  a_r10_uv_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q.uv && !clear_i) |=> flags_q.uv);

  // R10: undervoltage input sets the flag
  a_r10_uv_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_i && !clear_i) |=> flags_q.uv);

endmodule

// File: rtl/wake_signal_unit.sv
module wake_signal_unit
  import wake_pkg::*;
#(
  parameter int T_BUS = 8,
  parameter int T_WK  = 6,
  parameter int T_REL = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic [1:0] mode_i,
  input  logic       en_i,
  input  logic       txd_i,
  input  logic       vs_uv_i,
  input  logic       bus_rx_i,
  input  logic       wake_pin_i,
  output logic       wake_pulse_o,
  output logic       txd_o,
  output logic       txd_oe_o,
  output logic       rxd_o
);
  op_mode_e  mode;
  logic      sleep_ok;
  logic      bus_armed;
  logic      loc_armed;
  logic      bus_req;
  logic      loc_req;
  logic      clear_flags;
  wake_src_t flags;

  assign mode        = op_mode_e'(mode_i);
  assign sleep_ok    = (mode == MODE_SLEEP) && !vs_uv_i;
  assign bus_armed   = ((mode == MODE_SILENT) && txd_i) || sleep_ok;
  assign loc_armed   = (mode == MODE_SILENT) || sleep_ok;
  assign clear_flags = en_i && (mode == MODE_NORMAL);

  bus_wake_filter #(.FILT_TICKS(T_BUS)) u_bus (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .armed_i(bus_armed),
    .line_i (bus_rx_i),
    .req_o  (bus_req)
  );

  local_wake_filter #(.FILT_TICKS(T_WK), .REARM_TICKS(T_REL)) u_loc (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .armed_i(loc_armed),
    .pin_i  (wake_pin_i),
    .req_o  (loc_req)
  );

  wake_src_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req_i(bus_req),
    .loc_req_i(loc_req),
    .uv_i     (vs_uv_i),
    .clear_i  (clear_flags),
    .flags_o  (flags)
  );

  assign wake_pulse_o = bus_req | loc_req;

  always_comb begin
    txd_oe_o = 1'b0;
    txd_o    = 1'b1;
    rxd_o    = 1'b1;
    case (mode)
      MODE_NORMAL: rxd_o = bus_rx_i;
      MODE_SILENT: rxd_o = 1'b1;
      MODE_SLEEP:  rxd_o = 1'b0;
      default: begin
        txd_oe_o = 1'b1;
        if (flags.bus) begin
          txd_o = 1'b0; rxd_o = 1'b0;
        end else if (flags.loc) begin
          txd_o = 1'b0; rxd_o = 1'b1;
        end else if (flags.uv) begin
          txd_o = 1'b1; rxd_o = 1'b0;
        end
      end
    endcase
  end

  // R6: no wake from Sleep under undervoltage
  a_r6_sleep_uv_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse_o |-> !($past(mode == MODE_SLEEP) && $past(vs_uv_i)));

  // R7: wakes only from the armed low-power modes
  a_r7_armed_modes: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse_o |-> ($past(mode == MODE_SILENT) || $past(mode == MODE_SLEEP)));

  // R3: Silent-mode bus wake needs TXD high
  a_r3_silent_txd: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && $past(mode == MODE_SILENT)) |-> $past(txd_i));

  // R8: a low TXD code needs a latched wake source
  a_r8_code_source: assert property (@(posedge clk) disable iff (!rst_n)
    (txd_oe_o && !txd_o) |-> (flags.bus || flags.loc));

endmodule

// File: tb/wake_signal_unit_test.sv
`timescale 1ns/1ps
module wake_signal_unit_test;
  localparam int T_BUS = 8;
  localparam int T_WK  = 6;
  localparam int T_REL = 4;
  localparam logic [1:0] M_NOR = 2'd0, M_SIL = 2'd1, M_SLP = 2'd2, M_FS = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic [1:0] mode = M_FS;
  logic en = 1'b0, txd = 1'b1, vs_uv = 1'b0, bus = 1'b1, pin = 1'b1;
  logic wake_pulse, txd_o, txd_oe, rxd_o;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wake_signal_unit #(.T_BUS(T_BUS), .T_WK(T_WK), .T_REL(T_REL)) uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .mode_i(mode), .en_i(en),
    .txd_i(txd), .vs_uv_i(vs_uv), .bus_rx_i(bus), .wake_pin_i(pin),
    .wake_pulse_o(wake_pulse), .txd_o(txd_o), .txd_oe_o(txd_oe), .rxd_o(rxd_o)
  );

  always @(negedge clk) if (rst_n && wake_pulse) pulses++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  // expected {oe,txd,rxd} from mode, bus level and a bench-side flag model
  function automatic int exp_pins(input logic [1:0] m, input logic b,
                                  input bit fb, input bit fl, input bit fu);
    if (m == M_NOR) return {1'b0, 1'b1, b};
    if (m == M_SIL) return 3'b011;
    if (m == M_SLP) return 3'b010;
    if (fb) return 3'b100;
    if (fl) return 3'b101;
    if (fu) return 3'b110;
    return 3'b111;
  endfunction

  function automatic int pins();
    return {txd_oe, txd_o, rxd_o};
  endfunction

  task automatic bus_hold(input int len);
    bus = 1'b0; step(len); bus = 1'b1; step(3);
  endtask

  task automatic pin_hold(input int len);
    pin = 1'b0; step(len); pin = 1'b1;
  endtask

  task automatic clear_flags();
    mode = M_NOR; en = 1'b1; step(1); en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int p0;
    int run;
    void'($urandom(32'd2718));
    step(3);
    rst_n = 1'b1;
    step(1);
    // R13: reset state, R8: no flag gives 11 with TXD driven
    chk("R13 pulse", wake_pulse, 0);
    chk("R13/R8 idle code", pins(), 3'b111);

    // R2: exact filter length is too short
    mode = M_SIL; txd = 1'b1; step(2);
    p0 = pulses; bus_hold(T_BUS);
    chk("R2 short dominant", pulses - p0, 0);
    // R1: one more sample qualifies; pulse the cycle after the release
    p0 = pulses;
    bus = 1'b0; step(T_BUS + 1); bus = 1'b1; step(1);
    chk("R1 pulse timing", wake_pulse, 1);
    step(1);
    chk("R1 pulse width", wake_pulse, 0);
    chk("R1 pulse count", pulses - p0, 1);
    mode = M_FS; step(1);
    chk("R8 bus code", pins(), 3'b100);
    // R11: en high outside Normal does not clear
    en = 1'b1; step(2); en = 1'b0;
    chk("R11 no clear in FS", pins(), 3'b100);
    clear_flags(); mode = M_FS; step(1);
    chk("R11 cleared", pins(), 3'b111);

    // R3: Silent with TXD low ignores bus; Sleep does not care about TXD
    mode = M_SIL; txd = 1'b0; step(2);
    p0 = pulses; bus_hold(T_BUS + 3);
    chk("R3 silent txd low", pulses - p0, 0);
    mode = M_SLP; step(2);
    p0 = pulses; bus_hold(T_BUS + 3);
    chk("R3 sleep txd low", pulses - p0, 1);
    txd = 1'b1; clear_flags();

    // R4: local wake threshold
    mode = M_SIL; step(2);
    p0 = pulses; pin_hold(T_WK); step(T_REL + 2);
    chk("R4 short low", pulses - p0, 0);
    p0 = pulses; pin_hold(T_WK + 2);
    chk("R4 local wake", pulses - p0, 1);
    // R5: too short a high gap keeps the lockout
    step(T_REL - 1);
    p0 = pulses; pin_hold(T_WK + 3);
    chk("R5 early edge ignored", pulses - p0, 0);
    step(T_REL);
    p0 = pulses; pin_hold(T_WK + 3);
    chk("R5 rearmed", pulses - p0, 1);
    step(T_REL + 2);
    mode = M_FS; step(1);
    chk("R8 local code", pins(), 3'b101);
    clear_flags();

    // R6: Sleep with undervoltage blocks both sources
    mode = M_SLP; vs_uv = 1'b1; step(2);
    p0 = pulses; bus_hold(T_BUS + 3); pin_hold(T_WK + 3); step(T_REL + 2);
    chk("R6 sleep uv", pulses - p0, 0);
    vs_uv = 1'b0; mode = M_FS; step(2);
    chk("R10 uv code held", pins(), 3'b110);

    // R9: priority local over uv, bus over local
    mode = M_SIL; step(2);
    pin_hold(T_WK + 2); step(T_REL + 2);
    mode = M_FS; step(1);
    chk("R9 local over uv", pins(), 3'b101);
    mode = M_SIL; step(2);
    bus_hold(T_BUS + 2);
    mode = M_FS; step(1);
    chk("R9 bus over local", pins(), 3'b100);
    clear_flags(); mode = M_FS; step(1);
    chk("R11 all cleared", pins(), 3'b111);

    // R7: Normal and Fail-Safe never wake
    mode = M_NOR; step(2);
    p0 = pulses; bus_hold(T_BUS + 3); pin_hold(T_WK + 3); step(T_REL + 2);
    chk("R7 normal", pulses - p0, 0);
    mode = M_FS; step(2);
    p0 = pulses; bus_hold(T_BUS + 3); pin_hold(T_WK + 3); step(T_REL + 2);
    chk("R7 failsafe", pulses - p0, 0);

    // R12/R2: random modes and short dominant bursts
    p0 = pulses; run = 0;
    for (int i = 0; i < 400; i++) begin
      mode = 2'($urandom % 4);
      txd  = ($urandom % 2) == 1;
      if (run >= T_BUS - 1) bus = 1'b1;
      else bus = ($urandom % 3) != 0;
      run = bus ? 0 : run + 1;
      if (mode == M_SIL) txd = 1'b1;
      #1;
      chk("R12 pins per mode", pins(), exp_pins(mode, bus, 0, 0, 0));
      step(1);
    end
    bus = 1'b1; step(3);
    chk("R2 random bursts no wake", pulses - p0, 0);

    finish_run();
  end
endmodule